// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator Slice

This block drives two pulse-width-modulated lines from a single shared counter. The counter moves one step only when the slice is enabled and an external divider raises its one-cycle tick. Each output compares its own compare value against the live count. It is high while the compare value is above the count, and a per-channel invert bit can flip that level.

Two counting shapes are available. In sawtooth mode the count climbs from 0 to the wrap value and then drops back to 0. In centred (phase-correct) mode it climbs to the wrap value, holds there for one step, walks back down to 0 and holds there for one step. The pulses are then centred and the period is twice as long. Each period boundary raises a sticky flag that is cleared by writing a one. The wrap value and the compare values pass through shadow registers, so a change only takes effect at a period boundary or while the slice is stopped. A direct counter write port lets software preset or re-phase the count.

Top module: `pwm_slice_core`

## Requirements
- R1: After reset the count is 0, the flag is clear, both outputs are low, and the active wrap value is all ones until the first load.
- R2: An output is high exactly when its active compare value is strictly greater than the count, and low otherwise, before inversion.
- R3: A compare value of 0 keeps its output low for the whole period. A compare value of top+1 or more keeps it high for the whole period.
- R4: In sawtooth mode (phase_mode=0), each step adds one to the count. A step taken at a count greater than or equal to the active top gives 0, so the period is top+1 steps.
- R5: The count changes only on a clock edge where both run_en and tick_en are high, unless a counter write is present.
- R6: In centred mode (phase_mode=1), the count rises to top, spends one step holding at top, falls to 0 and spends one step holding at 0. The period is 2*(top+1) steps, and a compare value c gives 2*c high steps when c is at most top+1.
- R7: A period boundary is a step taken at count >= top in sawtooth mode, or a step taken at count 0 while falling in centred mode. It sets the wrap flag on that edge.
- R8: The wrap flag stays set until a cycle with wrap_clr=1 and no boundary. A boundary in the same cycle as wrap_clr leaves the flag set.
- R9: inv_a and inv_b each complement only their own output, and they act in the same cycle without waiting for a boundary.
- R10: With cnt_wr=1 the count equals cnt_wdata after the next edge. The write takes priority over a step in that cycle, and no boundary is signalled in that cycle.
- R11: top_in, cmp_a_in and cmp_b_in are copied into the active registers at a period boundary, and also on every edge while run_en=0. At all other times the active values hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Divider strobe; one count step per high cycle |
| run_en | input | 1 | Slice enable |
| phase_mode | input | 1 | 1 selects centred up/down counting |
| top_in | input | CNT_W | Requested wrap value |
| cmp_a_in | input | CNT_W | Requested compare value, channel A |
| cmp_b_in | input | CNT_W | Requested compare value, channel B |
| inv_a | input | 1 | Invert channel A |
| inv_b | input | 1 | Invert channel B |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| wrap_clr | input | 1 | Write-one-to-clear for the wrap flag |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| cnt_out | output | CNT_W | Live count |
| wrap_flag | output | 1 | Sticky period-boundary flag |

## Verification
The bench builds the slice with CNT_W=8. This makes the all-ones reset wrap value 255, so the default period can be crossed in a few cycles by presetting the count near it. Short wrap values of 0, 5, 7 and 9 keep complete sawtooth and centred periods short enough to count every high cycle. Compare values of 0, top+1 and 200 (well above top) reach the always-low and always-high limits in both modes.

// File: rtl/pwm_slice_pkg.sv
`timescale 1ns/1ps
package pwm_slice_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } count_dir_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
endpackage

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
  import pwm_slice_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             phase_mode,
  input  logic [CNT_W-1:0] top_act,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt,
  output count_dir_e       dir,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  // sawtooth: next count
  function automatic logic [CNT_W-1:0] saw_next(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] t);
    return (c >= t) ? ZERO : c + ONE;
  endfunction

  // centred: next count given direction (holds one step at each end)
  function automatic logic [CNT_W-1:0] ctr_next(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] t,
                                                input count_dir_e d);
    if (d == DIR_UP) return (c >= t) ? c : c + ONE;
    else             return (c == ZERO) ? c : c - ONE;
  endfunction

  function automatic count_dir_e ctr_dir(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] t,
                                         input count_dir_e d);
    if (d == DIR_UP) return (c >= t) ? DIR_DOWN : DIR_UP;
    else             return (c == ZERO) ? DIR_UP : DIR_DOWN;
  endfunction

  logic boundary_here;
  logic step_taken;

  assign step_taken    = step & ~cnt_wr;
  assign boundary_here = phase_mode ? ((dir == DIR_DOWN) && (cnt == ZERO))
                                    : (cnt >= top_act);
  assign wrap_evt      = step_taken & boundary_here;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
      dir <= DIR_UP;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (step) begin
      if (!phase_mode) begin
        cnt <= saw_next(cnt, top_act);
        dir <= DIR_UP;
      end else begin
        cnt <= ctr_next(cnt, top_act, dir);
        dir <= ctr_dir(cnt, top_act, dir);
      end
    end
  end

  // R5: no step and no write -> count frozen
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt));

  // R10: write lands on next edge
  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(cnt_wdata)));

  // R10: no boundary in a write cycle
  p_write_nowrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !wrap_evt);

  // R4: sawtooth step at or above top lands on zero
  p_saw_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && !phase_mode && (cnt >= top_act)) |=> (cnt == ZERO));

  // R6: centred rising step at top holds and turns down
  p_ctr_hold_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && phase_mode && dir == DIR_UP && (cnt >= top_act))
      |=> ($stable(cnt) && dir == DIR_DOWN));

  // R6: centred falling step never raises the count
  p_ctr_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && phase_mode && dir == DIR_DOWN) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/pwm_shadow.sv
`timescale 1ns/1ps
module pwm_shadow
  import pwm_slice_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [CNT_W-1:0]              top_in,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_in,
  output logic [CNT_W-1:0]              top_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_act <= '1;
    else if (load) top_act <= top_in;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_act[g] <= '0;
      else if (load) cmp_act[g] <= cmp_in[g];
    end

    p_cmp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cmp_act[g]));
  end

  // R11: active top only moves on a load
  p_top_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(top_act));

  p_top_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (top_act == $past(top_in)));
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             inv,
  output logic             pwm
);
  function automatic logic level(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] k,
                                 input logic i);
    return (c > k) ^ i;
  endfunction

  assign pwm = level(cmp, cnt, inv);

  // R3: zero compare never drives the active level
  p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> (pwm == inv));

  // R2: count at or above compare means inactive level
  p_above_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= cmp) |-> (pwm == inv));
endmodule

// File: rtl/pwm_wrap_flag.sv
`timescale 1ns/1ps
module pwm_wrap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R7: boundary always leaves the flag set
  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R8: sticky without clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr) |=> $stable(flag));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && clr) |=> !flag);
endmodule

// File: rtl/pwm_slice_core.sv
`timescale 1ns/1ps
module pwm_slice_core
  import pwm_slice_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run_en,
  input  logic             phase_mode,
  input  logic [CNT_W-1:0] top_in,
  input  logic [CNT_W-1:0] cmp_a_in,
  input  logic [CNT_W-1:0] cmp_b_in,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             wrap_clr,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] cnt_out,
  output logic             wrap_flag
);
  logic                         step;
  logic                         wrap_evt;
  logic                         shadow_load;
  logic [CNT_W-1:0]             top_act;
  logic [CNT_W-1:0]             cnt;
  count_dir_e                   dir;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_req;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  logic [NUM_CH-1:0]            inv_vec;
  logic [NUM_CH-1:0]            pwm_vec;

  assign step        = run_en & tick_en;
  assign shadow_load = wrap_evt | ~run_en;
  assign cmp_req     = {cmp_b_in, cmp_a_in};
  assign inv_vec     = {inv_b, inv_a};

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .phase_mode(phase_mode),
    .top_act(top_act), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt(cnt), .dir(dir), .wrap_evt(wrap_evt)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load), .top_in(top_in),
    .cmp_in(cmp_req), .top_act(top_act), .cmp_act(cmp_act)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .cmp(cmp_act[g]), .cnt(cnt),
      .inv(inv_vec[g]), .pwm(pwm_vec[g])
    );
  end

  pwm_wrap_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(wrap_evt), .clr(wrap_clr),
    .flag(wrap_flag)
  );

  assign pwm_a   = pwm_vec[CH_A];
  assign pwm_b   = pwm_vec[CH_B];
  assign cnt_out = cnt;

  // R7: boundaries only happen on a real step
  p_evt_needs_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> step);

  // R11: a stopped slice takes the requested top on the next edge
  p_stopped_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (top_act == $past(top_in)));
endmodule

// File: tb/tb_pwm_slice_core.sv
`timescale 1ns/1ps
module tb_pwm_slice_core;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, run_en = 1'b0, phase_mode = 1'b0;
  logic [W-1:0] top_in = '0, cmp_a_in = '0, cmp_b_in = '0, cnt_wdata = '0;
  logic inv_a = 1'b0, inv_b = 1'b0, cnt_wr = 1'b0, wrap_clr = 1'b0;
  logic pwm_a, pwm_b, wrap_flag;
  logic [W-1:0] cnt_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_slice_core #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .phase_mode(phase_mode), .top_in(top_in), .cmp_a_in(cmp_a_in),
    .cmp_b_in(cmp_b_in), .inv_a(inv_a), .inv_b(inv_b), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .wrap_clr(wrap_clr), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .cnt_out(cnt_out), .wrap_flag(wrap_flag)
  );

  typedef struct packed {
    logic [W-1:0] top;
    logic [W-1:0] ca;
    logic [W-1:0] cb;
    logic         ia;
    logic         ib;
    logic         ph;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
  } vec_t;

  // stimulus and expected high-step counts per full period
  localparam vec_t VECS [7] = '{
    '{8'd9, 8'd3,   8'd7,  1'b0, 1'b0, 1'b0, 8'd3,  8'd7 },
    '{8'd9, 8'd0,   8'd10, 1'b0, 1'b0, 1'b0, 8'd0,  8'd10},
    '{8'd9, 8'd4,   8'd2,  1'b0, 1'b1, 1'b0, 8'd4,  8'd8 },
    '{8'd5, 8'd2,   8'd6,  1'b0, 1'b0, 1'b1, 8'd4,  8'd12},
    '{8'd5, 8'd0,   8'd3,  1'b1, 1'b0, 1'b1, 8'd12, 8'd6 },
    '{8'd0, 8'd1,   8'd0,  1'b0, 1'b0, 1'b0, 8'd1,  8'd0 },
    '{8'd7, 8'd200, 8'd8,  1'b0, 1'b0, 1'b1, 8'd16, 8'd16}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic run_during);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 0; run_en = run_during; phase_mode = 0;
    top_in = '0; cmp_a_in = '0; cmp_b_in = '0; inv_a = 0; inv_b = 0;
    cnt_wr = 0; cnt_wdata = '0; wrap_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // ---- table walk: R2 R3 R4 R6 R7 R9 ----
    for (int v = 0; v < 7; v++) begin
      int ha, hb, per;
      do_reset(1'b0);
      top_in = VECS[v].top; cmp_a_in = VECS[v].ca; cmp_b_in = VECS[v].cb;
      inv_a = VECS[v].ia; inv_b = VECS[v].ib; phase_mode = VECS[v].ph;
      adv(1);
      run_en = 1; tick_en = 1; #1;
      ha = 0; hb = 0;
      per = (int'(VECS[v].top) + 1) * (VECS[v].ph ? 2 : 1);
      for (int i = 0; i < per; i++) begin
        ha += int'(pwm_a); hb += int'(pwm_b);
        if (i != per - 1) adv(1);
      end
      chk($sformatf("R2/R3/R6 vec%0d chA high steps", v), ha, int'(VECS[v].ea));
      chk($sformatf("R2/R9 vec%0d chB high steps", v), hb, int'(VECS[v].eb));
      chk($sformatf("R7 vec%0d flag before boundary", v), int'(wrap_flag), 0);
      adv(1);
      chk($sformatf("R7 vec%0d flag after boundary", v), int'(wrap_flag), 1);
      chk($sformatf("R4/R6 vec%0d count back at zero", v), int'(cnt_out), 0);
    end

    // ---- R1 reset state and default top ----
    do_reset(1'b1);
    chk("R1 count after reset", int'(cnt_out), 0);
    chk("R1 flag after reset", int'(wrap_flag), 0);
    chk("R1 pwm_a after reset", int'(pwm_a), 0);
    chk("R1 pwm_b after reset", int'(pwm_b), 0);
    top_in = 8'd5;
    cnt_wr = 1; cnt_wdata = 8'd254;
    adv(1);
    cnt_wr = 0; tick_en = 1;
    adv(1);
    chk("R1 default top passes 254->255", int'(cnt_out), 255);
    adv(1);
    chk("R1/R4 wrap at default top", int'(cnt_out), 0);
    chk("R7 flag at default wrap", int'(wrap_flag), 1);

    // ---- R5 step gating ----
    tick_en = 0;
    adv(3);
    chk("R5 no tick holds count", int'(cnt_out), 0);
    tick_en = 1;
    adv(1);
    chk("R5 tick advances", int'(cnt_out), 1);
    run_en = 0;
    adv(2);
    chk("R5 disabled holds count", int'(cnt_out), 1);

    // ---- R10 counter write ----
    cnt_wr = 1; cnt_wdata = 8'd5; wrap_clr = 1;
    adv(1);
    wrap_clr = 0;
    chk("R8 clear drops flag", int'(wrap_flag), 0);
    chk("R10 write while stopped", int'(cnt_out), 5);
    run_en = 1; tick_en = 1; cnt_wdata = 8'd2;
    adv(1);
    cnt_wr = 0;
    chk("R10 write beats step at top", int'(cnt_out), 2);
    chk("R10 no boundary on write", int'(wrap_flag), 0);

    // ---- R8 sticky flag ----
    adv(4);
    chk("R4 wrap at loaded top 5", int'(cnt_out), 0);
    chk("R8 flag set", int'(wrap_flag), 1);
    tick_en = 0;
    adv(2);
    chk("R8 flag sticky", int'(wrap_flag), 1);
    wrap_clr = 1;
    adv(1);
    wrap_clr = 0;
    chk("R8 clear works", int'(wrap_flag), 0);
    cnt_wr = 1; cnt_wdata = 8'd5;
    adv(1);
    cnt_wr = 0; tick_en = 1; wrap_clr = 1;
    adv(1);
    wrap_clr = 0;
    chk("R8 set wins over clear", int'(wrap_flag), 1);

    // ---- R11 shadowed top/compare ----
    do_reset(1'b0);
    top_in = 8'd9; cmp_a_in = 8'd3;
    adv(1);
    run_en = 1; tick_en = 1;
    adv(5);
    cmp_a_in = 8'd8; top_in = 8'd20; #1;
    chk("R11 old compare still active", int'(pwm_a), 0);
    adv(4);
    chk("R11 old top still active", int'(cnt_out), 9);
    adv(1);
    chk("R11 wrap at old top", int'(cnt_out), 0);
    adv(5);
    chk("R11 new compare after boundary", int'(pwm_a), 1);
    adv(5);
    chk("R11 new top after boundary", int'(cnt_out), 10);

    // ---- R9 immediate per-channel invert ----
    chk("R9 pwm_a low before invert", int'(pwm_a), 0);
    inv_a = 1; #1;
    chk("R9 inv_a flips A at once", int'(pwm_a), 1);
    chk("R9 inv_a leaves B", int'(pwm_b), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule